// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block drives the control pins of an integer-multiplier PLL that feeds a four-channel clock synthesizer. A one-cycle enable request starts a power-up sequence that changes one control output per clock cycle. First the PLL's block reset is released. Then the reference bandwidth code is loaded, then the feedback divider, and last the power-down pin is released. The sequencer then waits for the PLL's lock input. It finishes with a done pulse when lock arrives, or with a timeout pulse when the wait runs out. A one-cycle disable request first powers the PLL down and then puts it back into reset.

Options are set by parameters. The PLL may or may not have a block-reset pin. The PLL may or may not report lock. The power-down pin may be active high or active low. The lock timeout is given in system clock cycles; the default of 1,000,000 cycles equals 10 ms at 100 MHz. The PLL multiplies its reference by the divider field value plus 16, so the 3-bit field selects a factor from 16 to 23. The analog PLL is not part of the block.

Top module: `pll_lock_seq`

## Requirements
- R1: After reset the block is idle, with busy, done and timeout all low. The divider and bandwidth outputs are 0. The power-down pin is at its powered-down level `PDN_LEVEL`, so enabled reads 0. The block-reset output is 0 (reset applied) when reset control is present, and is tied to 1 otherwise.
- R2: Take the clock edge that accepts an enable request as edge 0. The block reset is released after edge 1, the bandwidth code is loaded after edge 2, the divider is loaded after edge 3 and the power-down pin is released after edge 4. Only one of these outputs changes per edge.
- R3: The bandwidth output is a 2-bit code with these values: 0 = good reference, 1 = very bad, 2 = bad, 3 = very good. The sequencer only ever loads 0.
- R4: The divider output takes the value of `div_set` sampled on the edge that accepts the enable request. Changes to `div_set` after that edge have no effect on that sequence. The PLL multiplies its reference by the divider value plus 16.
- R5: With lock status present, the block waits from edge 5 onward. On the first edge that samples `pll_lock` high, it raises `seq_done` for one cycle and drops `seq_busy`.
- R6: If `pll_lock` is low for `TIMEOUT_CYCLES` consecutive wait edges, the block raises `seq_timeout` for one cycle instead of done and returns to idle. Lock sampled on that last edge counts as success. Done and timeout are never high together.
- R7: `pll_enabled` is 1 exactly when `pll_pdn` differs from `PDN_LEVEL`. `pll_enabled` changes only as a step of a sequence.
- R8: On a disable request, `pll_pdn` goes to `PDN_LEVEL` after edge 1. After edge 2 the block reset is applied (when present) and `seq_done` pulses.
- R9: `seq_busy` is high from the accepting edge until the sequence ends. Enable and disable requests that arrive while busy are ignored.
- R10: If enable and disable are requested in the same idle cycle, the disable sequence runs.
- R11: Without lock status, done pulses right after the power-up step (edge 4) with no wait. Without reset control, the block-reset output stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | One-cycle power-up request |
| dis_req | input | 1 | One-cycle power-down request |
| div_set | input | DIV_W | Feedback divider value for the next power-up |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_rst_n | output | 1 | PLL block reset, active low |
| pll_bw | output | 2 | Reference bandwidth code |
| pll_ndiv | output | DIV_W | Feedback divider field |
| pll_pdn | output | 1 | Power-down pin, level set by PDN_LEVEL |
| seq_busy | output | 1 | A sequence is in progress |
| seq_done | output | 1 | One-cycle pulse when a sequence completes |
| seq_timeout | output | 1 | One-cycle pulse when the lock wait expired |
| pll_enabled | output | 1 | PLL is powered up |

## Verification
The hardest case to reach from the ports is the boundary of the lock window, where lock arrives on exactly the last permitted wait edge. One cycle later it must become a timeout. The bench PLL model raises lock a programmable number of cycles after it sees power-up with the reset released. The delay is set to `TIMEOUT_CYCLES-1` for one run and to `TIMEOUT_CYCLES` for the next, so that both sides of the boundary are hit. Requests pulsed during a running sequence, and enable and disable pulsed together, cover the ignore and priority rules. A second instance without lock status or reset control, and with the opposite power-down polarity, is compared against the same reference model.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REL,
      ST_BW,
      ST_DIV,
      ST_PUP,
      ST_WAIT,
      ST_PDN,
      ST_HOLD
   } seq_state_t;

   typedef logic [1:0] bw_code_t;

   localparam bw_code_t BW_GOOD_REF  = 2'd0;
   localparam bw_code_t BW_VBAD_REF  = 2'd1;
   localparam bw_code_t BW_BAD_REF   = 2'd2;
   localparam bw_code_t BW_VGOOD_REF = 2'd3;

   localparam int MULT_OFFSET = 16;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
   parameter int LIMIT = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (cnt != LAST)
         cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == LAST);

   // R6: the window counter never passes its limit
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
   import pll_seq_pkg::*;
#(
   parameter int DIV_W = 3,
   parameter bit HAS_LOCK_STATUS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_req,
   input  logic             dis_req,
   input  logic [DIV_W-1:0] div_set,
   input  logic             pll_lock,
   input  logic             tmr_expired,
   output logic             tmr_run,
   output logic             do_rel,
   output logic             do_bw,
   output logic             do_div,
   output logic             do_pup,
   output logic             do_pdn,
   output logic             do_hold,
   output logic [DIV_W-1:0] div_q,
   output logic             seq_busy,
   output logic             seq_done,
   output logic             seq_timeout
);
   seq_state_t state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         div_q       <= '0;
         seq_done    <= 1'b0;
         seq_timeout <= 1'b0;
      end else begin
         seq_done    <= 1'b0;
         seq_timeout <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (dis_req)
                  state <= ST_PDN;
               else if (en_req) begin
                  state <= ST_REL;
                  div_q <= div_set;
               end
            end
            ST_REL:  state <= ST_BW;
            ST_BW:   state <= ST_DIV;
            ST_DIV:  state <= ST_PUP;
            ST_PUP: begin
               if (HAS_LOCK_STATUS)
                  state <= ST_WAIT;
               else begin
                  state    <= ST_IDLE;
                  seq_done <= 1'b1;
               end
            end
            ST_WAIT: begin
               if (pll_lock) begin
                  state    <= ST_IDLE;
                  seq_done <= 1'b1;
               end else if (tmr_expired) begin
                  state       <= ST_IDLE;
                  seq_timeout <= 1'b1;
               end
            end
            ST_PDN:  state <= ST_HOLD;
            ST_HOLD: begin
               state    <= ST_IDLE;
               seq_done <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      do_rel   = (state == ST_REL);
      do_bw    = (state == ST_BW);
      do_div   = (state == ST_DIV);
      do_pup   = (state == ST_PUP);
      do_pdn   = (state == ST_PDN);
      do_hold  = (state == ST_HOLD);
      tmr_run  = (state == ST_WAIT) && !pll_lock;
      seq_busy = (state != ST_IDLE);
   end

   // R4: the captured divider cannot move while a sequence runs
   p_div_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> $stable(div_q));

   // R5: a done pulse always leaves the sequencer idle
   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> !seq_busy);

   // R6: completion and expiry are exclusive
   p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_done && seq_timeout));

endmodule

// File: rtl/pll_seq_drive.sv
module pll_seq_drive
   import pll_seq_pkg::*;
#(
   parameter int DIV_W = 3,
   parameter bit HAS_RESET_CTRL = 1'b1,
   parameter bit PDN_LEVEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_rel,
   input  logic             do_bw,
   input  logic             do_div,
   input  logic             do_pup,
   input  logic             do_pdn,
   input  logic             do_hold,
   input  logic [DIV_W-1:0] div_q,
   output logic             pll_rst_n,
   output bw_code_t         pll_bw,
   output logic [DIV_W-1:0] pll_ndiv,
   output logic             pll_pdn
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_bw   <= BW_GOOD_REF;
         pll_ndiv <= '0;
         pll_pdn  <= PDN_LEVEL;
      end else begin
         if (do_bw)  pll_bw   <= BW_GOOD_REF;
         if (do_div) pll_ndiv <= div_q;
         if (do_pup) pll_pdn  <= ~PDN_LEVEL;
         if (do_pdn) pll_pdn  <= PDN_LEVEL;
      end
   end

   generate
      if (HAS_RESET_CTRL) begin : g_rst_ctrl
         logic rst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rst_q <= 1'b0;
            else if (do_rel)
               rst_q <= 1'b1;
            else if (do_hold)
               rst_q <= 1'b0;
         end
         assign pll_rst_n = rst_q;

         // R2: reset is already released when power-up is applied
         p_rel_before_pup_r2: assert property (@(posedge clk) disable iff (!rst_n)
            do_pup |-> pll_rst_n);

         // R8: reset is applied only after the PLL was powered down
         p_hold_after_pdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pll_rst_n) |-> ($past(pll_pdn) == PDN_LEVEL));
      end else begin : g_no_rst_ctrl
         logic unused_ok;
         assign unused_ok = do_rel ^ do_hold;
         assign pll_rst_n = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq
   import pll_seq_pkg::*;
#(
   parameter int DIV_W           = 3,
   parameter bit HAS_RESET_CTRL  = 1'b1,
   parameter bit HAS_LOCK_STATUS = 1'b1,
   parameter bit PDN_LEVEL       = 1'b1,
   parameter int TIMEOUT_CYCLES  = 1_000_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_req,
   input  logic             dis_req,
   input  logic [DIV_W-1:0] div_set,
   input  logic             pll_lock,
   output logic             pll_rst_n,
   output logic [1:0]       pll_bw,
   output logic [DIV_W-1:0] pll_ndiv,
   output logic             pll_pdn,
   output logic             seq_busy,
   output logic             seq_done,
   output logic             seq_timeout,
   output logic             pll_enabled
);
   generate
      if (DIV_W < 1) begin : g_bad_div_w
         $error("pll_lock_seq: DIV_W must be at least 1");
      end
      if (TIMEOUT_CYCLES < 2) begin : g_bad_timeout
         $error("pll_lock_seq: TIMEOUT_CYCLES must be at least 2");
      end
   endgenerate

   logic             tmr_run, tmr_expired;
   logic             do_rel, do_bw, do_div, do_pup, do_pdn, do_hold;
   logic [DIV_W-1:0] div_q;

   pll_seq_fsm #(
      .DIV_W           (DIV_W),
      .HAS_LOCK_STATUS (HAS_LOCK_STATUS)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_req      (en_req),
      .dis_req     (dis_req),
      .div_set     (div_set),
      .pll_lock    (pll_lock),
      .tmr_expired (tmr_expired),
      .tmr_run     (tmr_run),
      .do_rel      (do_rel),
      .do_bw       (do_bw),
      .do_div      (do_div),
      .do_pup      (do_pup),
      .do_pdn      (do_pdn),
      .do_hold     (do_hold),
      .div_q       (div_q),
      .seq_busy    (seq_busy),
      .seq_done    (seq_done),
      .seq_timeout (seq_timeout)
   );

   generate
      if (HAS_LOCK_STATUS) begin : g_lock_wait
         pll_seq_timer #(
            .LIMIT (TIMEOUT_CYCLES)
         ) u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (tmr_run),
            .expired (tmr_expired)
         );
      end else begin : g_no_lock_wait
         logic unused_run;
         assign unused_run  = tmr_run;
         assign tmr_expired = 1'b0;
      end
   endgenerate

   pll_seq_drive #(
      .DIV_W          (DIV_W),
      .HAS_RESET_CTRL (HAS_RESET_CTRL),
      .PDN_LEVEL      (PDN_LEVEL)
   ) u_drive (
      .clk       (clk),
      .rst_n     (rst_n),
      .do_rel    (do_rel),
      .do_bw     (do_bw),
      .do_div    (do_div),
      .do_pup    (do_pup),
      .do_pdn    (do_pdn),
      .do_hold   (do_hold),
      .div_q     (div_q),
      .pll_rst_n (pll_rst_n),
      .pll_bw    (pll_bw),
      .pll_ndiv  (pll_ndiv),
      .pll_pdn   (pll_pdn)
   );

   assign pll_enabled = (pll_pdn != PDN_LEVEL);

   // R7: the enabled status moves only as a step of a running sequence
   p_en_in_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_enabled != $past(pll_enabled)) |-> $past(seq_busy));

   // R9: a request while busy never restarts the sequence from idle
   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_busy && !seq_done && !seq_timeout && $past(seq_busy) && (pll_ndiv != $past(pll_ndiv)))
      |-> $past(seq_busy, 2));

endmodule

// File: tb/pll_lock_seq_bench.sv
`timescale 1ns/1ps
module pll_lock_seq_bench;

   localparam int TA = 8;
   localparam int TB = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_req = 1'b0, dis_req = 1'b0;
   logic [2:0] div_set = 3'd0;
   logic       lk [2];

   logic       a_rn, a_pdn, a_busy, a_done, a_to, a_en;
   logic [1:0] a_bw;
   logic [2:0] a_nd;
   logic       b_rn, b_pdn, b_busy, b_done, b_to, b_en;
   logic [1:0] b_bw;
   logic [2:0] b_nd;

   int n_chk = 0, n_fail = 0;
   bit cmp_on = 1'b0;
   bit ended = 1'b0;
   int dly [2];
   int pcnt [2];

   always #5 clk = ~clk;

   pll_lock_seq #(.DIV_W(3), .HAS_RESET_CTRL(1'b1), .HAS_LOCK_STATUS(1'b1),
                  .PDN_LEVEL(1'b1), .TIMEOUT_CYCLES(TA)) u_pll_lock_seq (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
      .div_set(div_set), .pll_lock(lk[0]), .pll_rst_n(a_rn), .pll_bw(a_bw),
      .pll_ndiv(a_nd), .pll_pdn(a_pdn), .seq_busy(a_busy), .seq_done(a_done),
      .seq_timeout(a_to), .pll_enabled(a_en));

   pll_lock_seq #(.DIV_W(3), .HAS_RESET_CTRL(1'b0), .HAS_LOCK_STATUS(1'b0),
                  .PDN_LEVEL(1'b0), .TIMEOUT_CYCLES(TB)) u_pll_lock_seq_alt (
      .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
      .div_set(div_set), .pll_lock(lk[1]), .pll_rst_n(b_rn), .pll_bw(b_bw),
      .pll_ndiv(b_nd), .pll_pdn(b_pdn), .seq_busy(b_busy), .seq_done(b_done),
      .seq_timeout(b_to), .pll_enabled(b_en));

   // analog PLL model: lock comes dly cycles after power-up with reset released
   always @(posedge clk) begin
      for (int i = 0; i < 2; i++) begin
         logic pw, rl;
         pw = (i == 0) ? (a_pdn != 1'b1) : (b_pdn != 1'b0);
         rl = (i == 0) ? a_rn : b_rn;
         if (!rst_n || !pw || !rl) begin
            pcnt[i] <= 0;
            lk[i]   <= 1'b0;
         end else begin
            pcnt[i] <= pcnt[i] + 1;
            lk[i]   <= (pcnt[i] + 1 >= dly[i]);
         end
      end
   end

   // behavioural reference: mode 0 idle, 1 power-up, 2 power-down
   int m_mode [2] = '{0, 0};
   int m_step [2] = '{0, 0};
   int m_cnt  [2] = '{0, 0};
   int m_div  [2] = '{0, 0};
   int m_nd   [2] = '{0, 0};
   int m_bw   [2] = '{0, 0};
   bit m_rn   [2] = '{0, 1};
   bit m_pdn  [2] = '{1, 0};
   bit m_done [2] = '{0, 0};
   bit m_to   [2] = '{0, 0};

   task automatic mdl_step(input int i);
      bit hr, hl, pl;
      int t;
      hr = (i == 0); hl = (i == 0); pl = (i == 0); t = (i == 0) ? TA : TB;
      if (!rst_n) begin
         m_mode[i] = 0; m_nd[i] = 0; m_bw[i] = 0; m_rn[i] = !hr; m_pdn[i] = pl;
         m_done[i] = 0; m_to[i] = 0; m_div[i] = 0;
         return;
      end
      m_done[i] = 0; m_to[i] = 0;
      if (m_mode[i] == 0) begin
         if (dis_req) begin m_mode[i] = 2; m_step[i] = 0; end
         else if (en_req) begin m_mode[i] = 1; m_step[i] = 0; m_div[i] = div_set; end
      end else if (m_mode[i] == 1) begin
         case (m_step[i])
            0: begin if (hr) m_rn[i] = 1; m_step[i] = 1; end
            1: begin m_bw[i] = 0; m_step[i] = 2; end
            2: begin m_nd[i] = m_div[i]; m_step[i] = 3; end
            3: begin
               m_pdn[i] = !pl;
               if (!hl) begin m_done[i] = 1; m_mode[i] = 0; end
               else begin m_step[i] = 4; m_cnt[i] = 0; end
            end
            default: begin
               if (lk[i]) begin m_done[i] = 1; m_mode[i] = 0; end
               else if (m_cnt[i] == t - 1) begin m_to[i] = 1; m_mode[i] = 0; end
               else m_cnt[i]++;
            end
         endcase
      end else begin
         if (m_step[i] == 0) begin m_pdn[i] = pl; m_step[i] = 1; end
         else begin if (hr) m_rn[i] = 0; m_done[i] = 1; m_mode[i] = 0; end
      end
   endtask

   always @(posedge clk) begin
      mdl_step(0);
      mdl_step(1);
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   task automatic cmp_inst(input int i, input logic rn, input logic [1:0] bw,
                           input logic [2:0] nd, input logic pdn, input logic busy,
                           input logic done, input logic to, input logic en);
      bit pl;
      pl = (i == 0);
      chk("R2 block reset", rn, m_rn[i]);
      chk("R3 bandwidth code", bw, m_bw[i]);
      chk("R4 divider", nd, m_nd[i]);
      chk("R7 power-down pin", pdn, m_pdn[i]);
      chk("R7 enabled", en, m_pdn[i] != pl);
      chk("R9 busy", busy, m_mode[i] != 0);
      chk((i == 0) ? "R5 done" : "R11 done", done, m_done[i]);
      chk("R6 timeout", to, m_to[i]);
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         cmp_inst(0, a_rn, a_bw, a_nd, a_pdn, a_busy, a_done, a_to, a_en);
         cmp_inst(1, b_rn, b_bw, b_nd, b_pdn, b_busy, b_done, b_to, b_en);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse(input bit e, input bit d, input logic [2:0] v);
      @(negedge clk); #1;
      en_req = e; dis_req = d; div_set = v;
      @(negedge clk); #1;
      en_req = 1'b0; dis_req = 1'b0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      dly[0] = 2; dly[1] = 0;
      lk[0] = 1'b0; lk[1] = 1'b0;
      idle(3);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1: reset state at the ports
      chk("R1 busy", a_busy, 0);
      chk("R1 block reset applied", a_rn, 0);
      chk("R1 pdn at powered-down level", a_pdn, 1);
      chk("R1 enabled", a_en, 0);
      chk("R1 alt reset tied high", b_rn, 1);
      chk("R1 alt pdn level", b_pdn, 0);
      chk("R1 divider", a_nd, 0);

      // R2 R4 R5 R9: power-up with stray requests and divider changes mid-sequence
      pulse(1'b1, 1'b0, 3'd5);
      div_set = 3'd1;
      pulse(1'b1, 1'b0, 3'd6);
      pulse(1'b0, 1'b1, 3'd2);
      idle(10);
      chk("R4 divider captured", a_nd, 5);
      chk("R9 disable ignored while busy", a_en, 1);
      chk("R11 alt powered without lock", b_en, 1);

      // R8: power-down
      pulse(1'b0, 1'b1, 3'd0);
      idle(4);
      chk("R8 reset applied", a_rn, 0);
      chk("R8 powered down", a_en, 0);
      chk("R11 alt reset stays high", b_rn, 1);

      // R6: lock on the last allowed wait edge counts as success
      dly[0] = TA - 1;
      pulse(1'b1, 1'b0, 3'd2);
      idle(TA + 8);
      chk("R6 last-edge lock succeeds", a_en, 1);
      pulse(1'b0, 1'b1, 3'd0);
      idle(4);

      // R6: lock one cycle late gives a timeout
      dly[0] = TA;
      pulse(1'b1, 1'b0, 3'd7);
      idle(TA + 8);
      pulse(1'b0, 1'b1, 3'd0);
      idle(4);

      // R10: both requests together from idle -> disable path
      pulse(1'b1, 1'b1, 3'd3);
      idle(4);
      chk("R10 stays powered down", a_en, 0);
      chk("R10 divider untouched", a_nd, 7);

      // R5: immediate lock
      dly[0] = 0;
      pulse(1'b1, 1'b0, 3'd0);
      idle(10);
      chk("R5 enabled after lock", a_en, 1);
      pulse(1'b0, 1'b1, 3'd4);
      idle(4);
      finish_run();
   end

endmodule